// File: doc/BRIEF.md
# Converter Interrupt Aggregator with Sample Window Check

This block gathers the event strobes of an analog-to-digital converter subsystem into one interrupt line. Seven events arrive as single-cycle strobes from the sequencer and the two sample queues. The eighth event is produced inside the block: each valid sample is compared against a programmable window, and a sample outside it raises an out-of-range event.

Every event latches into a raw status vector whether or not it is enabled. An enable vector is changed by separate set and clear strobes that share one mask bus. Pending status is the raw status gated by the enables, and it drives a level interrupt. Status bits are cleared by a write-one-to-clear strobe. An end-of-interrupt strobe drops the line for one cycle, so an interrupt controller that senses edges sees a fresh rising edge when work is still pending.

The window limits are written together in one strobe. A write whose lower limit is above its upper limit is refused, and the previous limits stay in force.

Top module: `adc_irq_monitor`

## Requirements
- R1: After reset the raw status, enable vector and interrupt line are 0, the upper limit is 0x3FF and the lower limit is 0.
- R2: Status bits are assigned as follows: bit0 end of sequence, bit1 queue-0 threshold, bit2 queue-0 overrun, bit3 queue-0 underflow, bit4 queue-1 threshold, bit5 queue-1 overrun, bit6 queue-1 underflow, bit7 out of range. Strobe evt_in[i] sets raw bit i on the next clock edge, even when bit i is disabled.
- R3: A status clear strobe clears exactly the raw bits whose mask bit is 1, on the next edge. All other raw bits keep their value.
- R4: An event that arrives in the same cycle as a clear of the same bit leaves that bit set.
- R5: An enable-set strobe sets the masked enable bits and an enable-clear strobe clears them. When both strobes are given in the same cycle, the clear wins.
- R6: pend_sts equals raw_sts AND en_mask, bit by bit.
- R7: irq_out is high whenever any pending bit is 1 and no end-of-interrupt gap is in progress. It is low when nothing is pending.
- R8: After an end-of-interrupt strobe, irq_out is low for exactly one cycle. It then returns high if a pending bit is still set.
- R9: A valid sample sets raw bit 7 when it is greater than the upper limit or less than the lower limit. A sample equal to either limit does not set the bit.
- R10: A limit write with lower <= upper loads both limits. A limit write with lower > upper changes neither limit.
- R11: A sample presented while smp_valid is low has no effect on raw bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 7 | Event strobes for status bits 0..6 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| lim_wr | input | 1 | Limit write strobe |
| lim_hi_in | input | DW | Upper limit to write |
| lim_lo_in | input | DW | Lower limit to write |
| mask_in | input | 8 | Mask shared by the enable and clear strobes |
| en_set_wr | input | 1 | Enable the masked bits |
| en_clr_wr | input | 1 | Disable the masked bits |
| sts_clr_wr | input | 1 | Clear the masked raw status bits |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| lim_hi | output | DW | Current upper limit |
| lim_lo | output | DW | Current lower limit |
| en_mask | output | 8 | Current enable vector |
| raw_sts | output | 8 | Raw status |
| pend_sts | output | 8 | Enabled (pending) status |
| irq_out | output | 1 | Level interrupt |

## Verification
The bench builds the block with the default sample width of 10 bits. At that width the whole limit span from 0 to 0x3FF can be reached, so the table of window cases covers both extremes as well as the equal-to-limit edges. It also covers a zero-width window at 0 and a zero-width window at 0x3FF. Directed cases then exercise an event that collides with its own clear, simultaneous enable set and clear, the end-of-interrupt gap both with and without pending work, and a refused limit write.

// File: rtl/adc_irq_monitor.sv
module adc_irq_monitor #(
  parameter int DW = 10,
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-2:0] evt_in,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  input  logic           lim_wr,
  input  logic [DW-1:0]  lim_hi_in,
  input  logic [DW-1:0]  lim_lo_in,
  input  logic [NEV-1:0] mask_in,
  input  logic           en_set_wr,
  input  logic           en_clr_wr,
  input  logic           sts_clr_wr,
  input  logic           eoi_wr,
  output logic [DW-1:0]  lim_hi,
  output logic [DW-1:0]  lim_lo,
  output logic [NEV-1:0] en_mask,
  output logic [NEV-1:0] raw_sts,
  output logic [NEV-1:0] pend_sts,
  output logic           irq_out
);

  localparam logic [DW-1:0] LIM_TOP = {DW{1'b1}};

  logic           oor_evt;
  logic [NEV-1:0] set_vec;
  logic [NEV-1:0] clr_vec;
  logic           eoi_gap;

  assign oor_evt  = smp_valid && ((smp_data > lim_hi) || (smp_data < lim_lo));
  assign set_vec  = {oor_evt, evt_in};
  assign clr_vec  = sts_clr_wr ? mask_in : '0;
  assign pend_sts = raw_sts & en_mask;
  assign irq_out  = (|pend_sts) && !eoi_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_sts <= '0;
    end else begin
      raw_sts <= (raw_sts & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0;
    end else begin
      en_mask <= (en_mask | (en_set_wr ? mask_in : '0)) & ~(en_clr_wr ? mask_in : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_hi <= LIM_TOP;
      lim_lo <= '0;
    end else if (lim_wr && (lim_lo_in <= lim_hi_in)) begin
      lim_hi <= lim_hi_in;
      lim_lo <= lim_lo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoi_gap <= 1'b0;
    else        eoi_gap <= eoi_wr;
  end

  // R3: a raw bit may only fall where a clear was requested
  a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(raw_sts) & ~raw_sts) & ~($past(sts_clr_wr) ? $past(mask_in) : '0)) == '0);

  // R2 / R4: every event strobe is visible on the next edge, clear or not
  a_r4_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_in) & ~raw_sts[NEV-2:0]) == '0);

  // R5: an enable bit may only rise where a set was requested
  a_r5_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_mask & ~$past(en_mask)) & ~($past(en_set_wr) ? $past(mask_in) : '0)) == '0);

  // R8: the line is low in the cycle after an end-of-interrupt
  a_r8_eoi_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eoi_wr) |-> !irq_out);

  // R9: a sample above the upper limit raises the range bit
  a_r9_above_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_data > lim_hi)) |=> raw_sts[NEV-1]);

  // R10: the limits never cross
  a_r10_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    lim_lo <= lim_hi);

endmodule

// File: tb/adc_irq_monitor_bench.sv
module adc_irq_monitor_bench;
  localparam int DW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [6:0] evt_in = '0;
  logic smp_valid = 0;
  logic [DW-1:0] smp_data = '0;
  logic lim_wr = 0;
  logic [DW-1:0] lim_hi_in = '0, lim_lo_in = '0;
  logic [7:0] mask_in = '0;
  logic en_set_wr = 0, en_clr_wr = 0, sts_clr_wr = 0, eoi_wr = 0;
  logic [DW-1:0] lim_hi, lim_lo;
  logic [7:0] en_mask, raw_sts, pend_sts;
  logic irq_out;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_irq_monitor #(.DW(DW), .NEV(8)) u_adc_irq_monitor (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .smp_valid(smp_valid),
    .smp_data(smp_data), .lim_wr(lim_wr), .lim_hi_in(lim_hi_in),
    .lim_lo_in(lim_lo_in), .mask_in(mask_in), .en_set_wr(en_set_wr),
    .en_clr_wr(en_clr_wr), .sts_clr_wr(sts_clr_wr), .eoi_wr(eoi_wr),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .en_mask(en_mask), .raw_sts(raw_sts),
    .pend_sts(pend_sts), .irq_out(irq_out));

  localparam logic [30:0] VEC [9] = '{
    {10'h3FF, 10'h000, 10'h3FF, 1'b0},
    {10'h3FF, 10'h000, 10'h000, 1'b0},
    {10'h200, 10'h100, 10'h201, 1'b1},
    {10'h200, 10'h100, 10'h200, 1'b0},
    {10'h200, 10'h100, 10'h100, 1'b0},
    {10'h200, 10'h100, 10'h0FF, 1'b1},
    {10'h000, 10'h000, 10'h000, 1'b0},
    {10'h000, 10'h000, 10'h001, 1'b1},
    {10'h3FF, 10'h3FF, 10'h3FE, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    evt_in = '0; smp_valid = 0; lim_wr = 0; en_set_wr = 0;
    en_clr_wr = 0; sts_clr_wr = 0; eoi_wr = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1 raw", raw_sts, 0);
    chk("R1 en", en_mask, 0);
    chk("R1 irq", irq_out, 0);
    chk("R1 hi", lim_hi, 10'h3FF);
    chk("R1 lo", lim_lo, 0);

    // R9 / R10 window table
    for (int i = 0; i < 9; i++) begin
      lim_wr = 1; lim_hi_in = VEC[i][30:21]; lim_lo_in = VEC[i][20:11];
      step();
      sts_clr_wr = 1; mask_in = 8'h80;
      step();
      smp_valid = 1; smp_data = VEC[i][10:1];
      step();
      chk("R9 window", raw_sts[7], VEC[i][0]);
    end
    sts_clr_wr = 1; mask_in = 8'hFF;
    step();

    // R11 ignored sample
    lim_wr = 1; lim_hi_in = 10'h010; lim_lo_in = 10'h008;
    step();
    smp_valid = 0; smp_data = 10'h3FF;
    step();
    chk("R11 no valid", raw_sts[7], 0);

    // R10 refused write
    lim_wr = 1; lim_hi_in = 10'h005; lim_lo_in = 10'h009;
    step();
    chk("R10 hi kept", lim_hi, 10'h010);
    chk("R10 lo kept", lim_lo, 10'h008);

    // R2 disabled events still latch
    evt_in = 7'b0000101;
    step();
    chk("R2 raw", raw_sts, 8'h05);
    chk("R6 pend none", pend_sts, 0);
    chk("R7 irq idle", irq_out, 0);

    // R5 / R6 / R7
    en_set_wr = 1; mask_in = 8'h04;
    step();
    chk("R5 set", en_mask, 8'h04);
    chk("R6 pend", pend_sts, 8'h04);
    chk("R7 irq", irq_out, 1);
    en_set_wr = 1; en_clr_wr = 1; mask_in = 8'h04;
    step();
    chk("R5 clear wins", en_mask, 0);
    chk("R7 irq drop", irq_out, 0);

    // R3 selective clear
    sts_clr_wr = 1; mask_in = 8'h01;
    step();
    chk("R3 clear", raw_sts, 8'h04);

    // R4 collision
    evt_in = 7'b0000010; sts_clr_wr = 1; mask_in = 8'h02;
    step();
    chk("R4 collide", raw_sts, 8'h06);

    // R8 eoi with pending work
    en_set_wr = 1; mask_in = 8'h06;
    step();
    chk("R8 before", irq_out, 1);
    eoi_wr = 1;
    step();
    chk("R8 gap", irq_out, 0);
    step();
    chk("R8 rearm", irq_out, 1);

    // R8 eoi with nothing pending
    sts_clr_wr = 1; mask_in = 8'hFF;
    step();
    eoi_wr = 1;
    step();
    step();
    chk("R8 idle", irq_out, 0);

    finish_run();
  end
endmodule